// File: doc/BRIEF.md
# Capture/Compare Timer Channel Unit

This block pairs a free-running 16-bit time base with a bank of event channels. Three channels latch the time base when a chosen edge arrives on their input pins. Four channels compare the time base against a programmed value and raise a flag on a match; three of these also drive an output pin. A fifth channel shares one data register between two roles: it acts as a fourth capture channel or a fifth compare channel, depending on a mode bit.

The time base advances on a tick from a power-of-two prescaler. Every capture, match and wrap of the counter sets a sticky flag. Software clears a flag by writing a one to its bit. A single interrupt line combines each flag with its enable bit. Software reaches all state through a flat 16-entry read/write port. Reads return data combinationally, and writes take effect at the next clock edge.

Top module: `cc_timer_unit`

## Requirements
- R1: The counter advances by one on each prescaler tick. The divide select is in MASK bits 2:0 and gives one tick every 2^sel clocks, for sel from 0 to 7. Writes to COUNT (address 0) have no effect.
- R2: When the counter steps from 0xFFFF to 0x0000, the overflow flag (FLAG bit 3) sets.
- R3: A capture register holds the counter value from the cycle after the second rising clock edge that samples the new pin level.
- R4: The edge field of capture channel n (n = 1..4) sits in OUTCTL bits 2n-1:2n-2 and is encoded as follows: 00 = off, 01 = rising only, 10 = falling only, 11 = both edges. An edge that is not selected changes neither the register nor the flag.
- R5: The action field of compare channel n (n = 2..5) sits in OUTCTL bits 2n+5:2n+4 and is encoded as follows: 01 = toggle, 10 = drive low, 11 = drive high. The match happens in the last cycle in which the counter equals the data register. The flag and the pin change at the clock edge that ends that cycle. Compare channel 1 sets only its flag.
- R6: Action 00 leaves the compare pin at its last value.
- R7: MODE bit 0 selects the role of the shared channel. With 0 it captures from cap_in[3] into SHARED. With 1 it compares SHARED against the counter and drives cmp_out[3]. Capture edges are ignored in compare mode. Matches are suppressed in capture mode, and the pin holds.
- R8: After reset, SHARED and CMP1..CMP4 read 0xFFFF. OUTCTL, MASK, FLAG, MODE, CAP1..CAP3, cmp_out and irq are all 0.
- R9: The FLAG bits are: 3 = overflow, 6:4 = capture 1..3, 10:7 = compare 1..4, 11 = shared channel. Writing a 1 to a bit clears it; writing a 0 leaves it unchanged.
- R10: irq is high exactly when some FLAG bit is set and the MASK bit in the same position is also set.
- R11: With a prescaler divide above 1, a match fires only once per counter value. A toggle action therefore inverts the pin exactly once.
- R12: The register addresses are: 0 COUNT, 1 OUTCTL, 2 MASK, 3 FLAG, 4 MODE, 8..10 CAP1..CAP3 (read only), 11..14 CMP1..CMP4, 15 SHARED. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for addr (combinational) |
| cap_in | input | 4 | Capture pins, channels 1..4 (bit 3 shared) |
| cmp_out | output | 4 | Compare pins, channels 2..5 (bit 3 shared) |
| irq | output | 1 | Combined interrupt |

## Verification
The cycle-by-cycle assertions cover these behaviours:
- the counter holds or steps on a tick, and always ticks at divide 1;
- the counter wraps and sets the overflow flag;
- a write of one clears the overflow flag;
- a disconnected pin holds its value, and the shared pin is frozen in capture mode;
- a write-free SHARED register stays unchanged in compare mode;
- irq stays low while all enables are off.

Only the bench scenarios can show the rest. These are the exact capture latency and the value captured for each edge setting, the match cycle and its pin action, the prescaler rates, single firing under prescale, and the combined interrupt for mixed enable patterns.

// File: rtl/cct_pkg.sv
`timescale 1ns/1ps
package cct_pkg;
   // channel counts: index NCAP-1 / NCMP-1 is the shared channel
   localparam int NCAP = 4;
   localparam int NCMP = 5;
   localparam int NFLG = NCAP + NCMP;  // overflow + 3 capture + 4 compare + shared

   typedef enum logic [1:0] {
      ACT_HOLD   = 2'b00,
      ACT_TOGGLE = 2'b01,
      ACT_LOW    = 2'b10,
      ACT_HIGH   = 2'b11
   } pin_act_e;

   localparam logic [3:0] A_COUNT  = 4'd0;
   localparam logic [3:0] A_OUTCTL = 4'd1;
   localparam logic [3:0] A_MASK   = 4'd2;
   localparam logic [3:0] A_FLAG   = 4'd3;
   localparam logic [3:0] A_MODE   = 4'd4;
   localparam logic [3:0] A_CAP1   = 4'd8;
   localparam logic [3:0] A_CMP1   = 4'd11;
   localparam logic [3:0] A_SHARED = 4'd15;
endpackage

// File: rtl/cct_prescale_counter.sv
`timescale 1ns/1ps
module cct_prescale_counter #(
   parameter int CNT_W = 16,
   parameter int PS_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PS_W-1:0]  ps_sel,
   output logic [CNT_W-1:0] count,
   output logic             tick,
   output logic             wrap
);
   localparam int DIV_W = (1 << PS_W) - 1;

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] div_mask;

   // tick when the low ps_sel bits of the free divider are all ones
   always_comb div_mask = DIV_W'((32'd1 << ps_sel) - 32'd1);
   assign tick = (div_q & div_mask) == div_mask;
   assign wrap = tick && (count == '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         count <= '0;
      end else begin
         div_q <= div_q + DIV_W'(1);
         if (tick) count <= count + CNT_W'(1);
      end
   end
endmodule

// File: rtl/cct_capture_ch.sv
`timescale 1ns/1ps
module cct_capture_ch #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin,
   input  logic       active,
   input  logic [1:0] edge_sel,
   output logic       evt
);
   logic [SYNC_STAGES:0] sh_q;
   logic now_v, was_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[SYNC_STAGES-1:0], pin};
   end

   assign now_v = sh_q[SYNC_STAGES-1];
   assign was_v = sh_q[SYNC_STAGES];
   assign evt   = active & ((edge_sel[0] & now_v & ~was_v) |
                            (edge_sel[1] & ~now_v & was_v));
endmodule

// File: rtl/cct_pin_driver.sv
`timescale 1ns/1ps
module cct_pin_driver
   import cct_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     hit,
   input  pin_act_e action,
   output logic     pin
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin <= 1'b0;
      else if (hit) begin
         case (action)
            ACT_TOGGLE: pin <= ~pin;
            ACT_LOW:    pin <= 1'b0;
            ACT_HIGH:   pin <= 1'b1;
            default:    pin <= pin;
         endcase
      end
   end
endmodule

// File: rtl/cc_timer_unit.sv
`timescale 1ns/1ps
module cc_timer_unit
   import cct_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int PS_W        = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       addr,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] rd_data,
   input  logic [NCAP-1:0]  cap_in,
   output logic [NCMP-2:0]  cmp_out,
   output logic             irq
);
   localparam int MSK_W = PS_W + NFLG;

   if (CNT_W < 16) begin : g_chk_w
      $error("CNT_W must hold the 16-bit control layout");
   end
   if (PS_W < 1 || PS_W > 4) begin : g_chk_ps
      $error("PS_W out of range");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (MSK_W > CNT_W) begin : g_chk_msk
      $error("mask layout wider than data path");
   end

   logic [CNT_W-1:0]            count_w;
   logic                        tick_w, wrap_w;
   logic [15:0]                 outctl_q;
   logic [MSK_W-1:0]            mask_q;
   logic [NFLG-1:0]             flags_q, flg_set, flg_clr;
   logic                        mode_q;
   logic [CNT_W-1:0]            shared_q;
   logic [NCAP-2:0][CNT_W-1:0]  cap_q;
   logic [NCMP-2:0][CNT_W-1:0]  cmp_q;
   logic [NCAP-1:0]             cap_evt;
   logic [NCMP-1:0]             cmp_hit;

   cct_prescale_counter #(.CNT_W(CNT_W), .PS_W(PS_W)) u_base (
      .clk    (clk),
      .rst_n  (rst_n),
      .ps_sel (mask_q[PS_W-1:0]),
      .count  (count_w),
      .tick   (tick_w),
      .wrap   (wrap_w)
   );

   for (genvar i = 0; i < NCAP; i++) begin : g_cap
      logic act;
      if (i == NCAP-1) begin : g_shr
         assign act = ~mode_q;
      end else begin : g_ded
         assign act = 1'b1;
      end
      cct_capture_ch #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
         .clk      (clk),
         .rst_n    (rst_n),
         .pin      (cap_in[i]),
         .active   (act),
         .edge_sel (outctl_q[2*i+1 -: 2]),
         .evt      (cap_evt[i])
      );
   end

   for (genvar j = 0; j < NCMP; j++) begin : g_cmp
      logic [CNT_W-1:0] ref_v;
      logic             act;
      if (j == NCMP-1) begin : g_shr
         assign ref_v = shared_q;
         assign act   = mode_q;
      end else begin : g_ded
         assign ref_v = cmp_q[j];
         assign act   = 1'b1;
      end
      // evaluated only on the tick cycle, so each counter value matches once
      assign cmp_hit[j] = act & tick_w & (count_w == ref_v);
      if (j > 0) begin : g_pin
         cct_pin_driver u_pin (
            .clk    (clk),
            .rst_n  (rst_n),
            .hit    (cmp_hit[j]),
            .action (pin_act_e'(outctl_q[2*j+7 -: 2])),
            .pin    (cmp_out[j-1])
         );
      end
   end

   assign flg_set = {cmp_hit[NCMP-1] | cap_evt[NCAP-1],
                     cmp_hit[NCMP-2:0], cap_evt[NCAP-2:0], wrap_w};
   assign flg_clr = (wr_en && addr == A_FLAG) ? wr_data[PS_W +: NFLG] : '0;
   assign irq     = |(flags_q & mask_q[MSK_W-1:PS_W]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         outctl_q <= '0;
         mask_q   <= '0;
         mode_q   <= 1'b0;
         flags_q  <= '0;
         shared_q <= '1;
         for (int k = 0; k < NCAP-1; k++) cap_q[k] <= '0;
         for (int k = 0; k < NCMP-1; k++) cmp_q[k] <= '1;
      end else begin
         if (wr_en) begin
            if (addr == A_OUTCTL) outctl_q <= wr_data[15:0];
            if (addr == A_MASK)   mask_q   <= wr_data[MSK_W-1:0];
            if (addr == A_MODE)   mode_q   <= wr_data[0];
            if (addr == A_SHARED) shared_q <= wr_data;
            for (int k = 0; k < NCMP-1; k++)
               if (addr == A_CMP1 + 4'(k)) cmp_q[k] <= wr_data;
         end
         for (int k = 0; k < NCAP-1; k++)
            if (cap_evt[k]) cap_q[k] <= count_w;
         if (cap_evt[NCAP-1]) shared_q <= count_w;  // capture wins over a write
         flags_q <= (flags_q & ~flg_clr) | flg_set;
      end
   end

   always_comb begin
      rd_data = '0;
      case (addr)
         A_COUNT:  rd_data = count_w;
         A_OUTCTL: rd_data = CNT_W'(outctl_q);
         A_MASK:   rd_data = CNT_W'(mask_q);
         A_FLAG:   rd_data = CNT_W'({flags_q, {PS_W{1'b0}}});
         A_MODE:   rd_data = CNT_W'(mode_q);
         A_SHARED: rd_data = shared_q;
         default:  rd_data = '0;
      endcase
      for (int k = 0; k < NCAP-1; k++)
         if (addr == A_CAP1 + 4'(k)) rd_data = cap_q[k];
      for (int k = 0; k < NCMP-1; k++)
         if (addr == A_CMP1 + 4'(k)) rd_data = cmp_q[k];
   end
endmodule

// File: rtl/cct_checker.sv
`timescale 1ns/1ps
module cct_checker
   import cct_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int PS_W  = 3
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [3:0]              addr,
   input logic                    wr_en,
   input logic [CNT_W-1:0]        wr_data,
   input logic [CNT_W-1:0]        count,
   input logic                    tick,
   input logic                    wrap,
   input logic [PS_W+NFLG-1:0]    mask,
   input logic [15:0]             outctl,
   input logic [NFLG-1:0]         flags,
   input logic                    mode,
   input logic [CNT_W-1:0]        shared,
   input logic [NCMP-2:0]         cmp_out,
   input logic                    irq
);
   a_r1_div1_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (mask[PS_W-1:0] == '0) |-> tick);

   a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(count));

   a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && count != '1) |=> (count == $past(count) + CNT_W'(1)));

   a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && count == '1) |=> (count == '0 && flags[0]));

   a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_FLAG && wr_data[PS_W] && !wrap) |=> !flags[0]);

   a_r7_shared_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (mode && !(wr_en && addr == A_SHARED)) |=> $stable(shared));

   a_r7_pin_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !mode |=> $stable(cmp_out[NCMP-2]));

   for (genvar c = 0; c < NCMP-1; c++) begin : g_hold
      a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (outctl[2*c+9 -: 2] == 2'b00) |=> $stable(cmp_out[c]));
   end

   a_r10_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mask[PS_W+NFLG-1:PS_W] == '0) |-> !irq);
endmodule

bind cc_timer_unit cct_checker #(.CNT_W(CNT_W), .PS_W(PS_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .addr    (addr),
   .wr_en   (wr_en),
   .wr_data (wr_data),
   .count   (count_w),
   .tick    (tick_w),
   .wrap    (wrap_w),
   .mask    (mask_q),
   .outctl  (outctl_q),
   .flags   (flags_q),
   .mode    (mode_q),
   .shared  (shared_q),
   .cmp_out (cmp_out),
   .irq     (irq)
);

// File: tb/cc_timer_unit_tb.sv
`timescale 1ns/1ps
module cc_timer_unit_tb;
   import cct_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic [3:0]  cap_in = '0;
   logic [3:0]  cmp_out;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   cc_timer_unit u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .cap_in(cap_in), .cmp_out(cmp_out), .irq(irq)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [3:0] a, logic [15:0] d);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [3:0] a, output logic [15:0] v);
      addr = a;
      #1;
      v = rd_data;
   endtask

   function automatic logic pin_next(logic [1:0] act, logic cur);
      case (act)
         2'b01:   return ~cur;
         2'b10:   return 1'b0;
         2'b11:   return 1'b1;
         default: return cur;
      endcase
   endfunction

   function automatic logic [3:0] cap_addr(int ch);
      return (ch == 3) ? A_SHARED : A_CAP1 + 4'(ch);
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] v, c, c2, f;
      logic [15:0] mcap [4];
      logic        cur [4];
      logic        mp [4];
      void'($urandom(32'd20240611));
      for (int i = 0; i < 4; i++) begin
         mcap[i] = (i == 3) ? 16'hFFFF : 16'h0000;
         cur[i] = 1'b0; mp[i] = 1'b0;
      end

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state and map
      rd(A_OUTCTL, v); chk("R8 outctl", v, 0);
      rd(A_MASK, v);   chk("R8 mask", v, 0);
      rd(A_FLAG, v);   chk("R8 flag", v, 0);
      rd(A_MODE, v);   chk("R8 mode", v, 0);
      rd(A_CAP1, v);   chk("R8 cap1", v, 0);
      rd(A_CMP1 + 4'd2, v); chk("R8 cmp3", v, 16'hFFFF);
      rd(A_SHARED, v); chk("R8 shared", v, 16'hFFFF);
      rd(4'd6, v);     chk("R12 unused addr", v, 0);
      chk("R8 pins", {28'd0, cmp_out}, 0);
      chk("R8 irq", {31'd0, irq}, 0);

      // counter at divide 1 and read-only COUNT
      rd(A_COUNT, c); @(negedge clk); rd(A_COUNT, c2);
      chk("R1 step", c2, c + 16'd1);
      wr(A_COUNT, 16'h1234); rd(A_COUNT, v);
      chk("R1 count write ignored", v, c2 + 16'd1);

      // prescaler rates
      for (int s = 0; s < 8; s++) begin
         int sel = (s + int'($urandom_range(0, 7))) % 8;
         wr(A_MASK, 16'(sel));
         rd(A_COUNT, c);
         repeat (128) @(negedge clk);
         rd(A_COUNT, c2);
         chk($sformatf("R1 divide sel=%0d", sel), c2 - c, 16'(128 >> sel));
      end
      wr(A_MASK, 16'h0000);

      // captures, shared channel in capture mode
      for (int it = 0; it < 24; it++) begin
         int ch = int'($urandom_range(0, 3));
         logic [1:0] es = 2'(it % 4);
         logic nl, fire;
         int fb;
         wr(A_OUTCTL, 16'(es) << (2*ch));
         wr(A_FLAG, 16'hFFF8);
         rd(A_COUNT, c);
         nl = ~cur[ch];
         cap_in[ch] = nl;
         fire = nl ? es[0] : es[1];
         repeat (3) @(negedge clk);
         if (fire) mcap[ch] = c + 16'd2;
         rd(cap_addr(ch), v);
         chk($sformatf("R3 capture ch%0d es=%0d", ch + 1, es), v, mcap[ch]);
         rd(A_FLAG, f);
         fb = (ch == 3) ? 11 : 4 + ch;
         chk($sformatf("R4 flag ch%0d es=%0d", ch + 1, es), {31'd0, f[fb]}, {31'd0, fire});
         cur[ch] = nl;
      end

      // shared channel in compare mode ignores capture edges
      wr(A_MODE, 16'h0001);
      wr(A_OUTCTL, 16'h00C0);
      wr(A_FLAG, 16'hFFF8);
      rd(A_SHARED, c);
      cap_in[3] = ~cur[3]; cur[3] = ~cur[3];
      repeat (4) @(negedge clk);
      rd(A_SHARED, v); chk("R7 capture ignored in compare mode", v, c);
      rd(A_FLAG, f);   chk("R7 no shared flag", {31'd0, f[11]}, 0);

      // compare channels
      for (int it = 0; it < 20; it++) begin
         int j = it % 5;
         logic [1:0] act = 2'($urandom_range(0, 3));
         int k = int'($urandom_range(3, 30));
         logic [3:0] a = (j == 4) ? A_SHARED : A_CMP1 + 4'(j);
         wr(A_OUTCTL, (j > 0) ? (16'(act) << (2*j + 6)) : 16'h0000);
         rd(A_COUNT, c);
         wr(a, c + 16'(k));
         wr(A_FLAG, 16'hFFF8);
         repeat (k - 2) @(negedge clk);
         rd(A_FLAG, f);
         chk($sformatf("R5 no early match ch%0d", j + 1), {31'd0, f[7+j]}, 0);
         if (j > 0) chk("R5 pin before match", {31'd0, cmp_out[j-1]}, {31'd0, mp[j-1]});
         @(negedge clk);
         rd(A_FLAG, f);
         chk($sformatf("R9 match flag ch%0d", j + 1), {31'd0, f[7+j]}, 1);
         if (j > 0) begin
            mp[j-1] = pin_next(act, mp[j-1]);
            chk($sformatf("R5 R6 pin ch%0d act=%0d", j + 1, act),
                {31'd0, cmp_out[j-1]}, {31'd0, mp[j-1]});
         end
      end

      // shared channel in capture mode suppresses matches
      wr(A_MODE, 16'h0000);
      wr(A_OUTCTL, 16'h4000);
      rd(A_COUNT, c);
      wr(A_SHARED, c + 16'd6);
      wr(A_FLAG, 16'hFFF8);
      repeat (10) @(negedge clk);
      rd(A_FLAG, f);
      chk("R7 match suppressed flag", {31'd0, f[11]}, 0);
      chk("R7 match suppressed pin", {31'd0, cmp_out[3]}, {31'd0, mp[3]});

      // single firing under prescale
      wr(A_MODE, 16'h0001);
      wr(A_MASK, 16'h0003);
      wr(A_OUTCTL, 16'h0100);
      rd(A_COUNT, c);
      wr(A_CMP1 + 4'd1, c + 16'd2);
      wr(A_FLAG, 16'hFFF8);
      repeat (60) @(negedge clk);
      mp[0] = ~mp[0];
      chk("R11 toggled once", {31'd0, cmp_out[0]}, {31'd0, mp[0]});
      rd(A_FLAG, f);
      chk("R11 flag", {31'd0, f[8]}, 1);

      // combined interrupt
      for (int it = 0; it < 6; it++) begin
         logic [8:0] en = (it == 0) ? 9'd0 : 9'($urandom_range(1, 511));
         wr(A_MASK, 16'(en) << 3);
         rd(A_FLAG, f);
         chk($sformatf("R10 irq en=%h", en), {31'd0, irq}, {31'd0, |(f[11:3] & en)});
      end

      // overflow and write-one-to-clear
      wr(A_MASK, 16'h0008);
      wr(A_FLAG, 16'hFFF8);
      rd(A_COUNT, v);
      while (v != 16'hFFFE) begin
         @(negedge clk);
         rd(A_COUNT, v);
      end
      rd(A_FLAG, f); chk("R2 no flag before wrap", {31'd0, f[3]}, 0);
      @(negedge clk); rd(A_COUNT, v); chk("R2 count top", v, 16'hFFFF);
      @(negedge clk); rd(A_COUNT, v); chk("R2 count wrapped", v, 16'h0000);
      rd(A_FLAG, f); chk("R2 overflow flag", {31'd0, f[3]}, 1);
      chk("R10 overflow irq", {31'd0, irq}, 1);
      wr(A_FLAG, 16'h0000);
      rd(A_FLAG, f); chk("R9 zero write keeps flag", {31'd0, f[3]}, 1);
      wr(A_FLAG, 16'h0008);
      rd(A_FLAG, f); chk("R9 cleared", {31'd0, f[3]}, 0);
      chk("R10 irq released", {31'd0, irq}, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule